// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the frame-sync (word-select) waveform for a serial audio cluster. It runs on the bit clock and divides it into frames made of a high phase and a low phase. The length of each phase is programmed separately, as the phase length in bit clocks minus one. For a frame of R bit clocks, software writes a high code of R/2 - 1 and a low code of ceil(R/2) - 1. An odd frame is then split as evenly as it can be, with the extra bit clock in the low phase.

Alongside the sync level, the block emits a frame-start strobe one bit clock wide. The serializers use it to align their slot counters. A single enable starts and stops generation. The phase lengths are captured at every frame boundary, so a write in the middle of a frame never shortens or stretches a phase that is already running. A 4-bit source select is decoded into a registered one-hot vector that steers an external master-clock multiplexer. Code k+1 picks source k.

The core is a three-state machine. IDLE is the disabled state: sync is low and the counter is cleared. HIGH is the high phase and LOAD_FIRST is not a separate state. The move IDLE->HIGH ("start", when enable is seen) captures the period codes. HIGH->LOW ("half", when the count reaches the captured high code) clears the counter. LOW->HIGH ("wrap", when the count reaches the captured low code) clears the counter and captures the period codes again. Any state goes to IDLE ("stop") in the first cycle enable is seen low.

Top module: `fsync_gen`

## Requirements
- R1: After reset, sync_o, frame_start_o and every bit of src_onehot_o are 0.
- R2: One clock after enable_i is sampled low, sync_o and frame_start_o are 0, and they stay 0 while it remains low. The first clock at which enable_i is sampled high starts a high phase.
- R3: Each high phase lasts hi_code_i + 1 bit clocks, using the code captured at the start of that frame.
- R4: Each low phase lasts lo_code_i + 1 bit clocks, using the code captured at the start of that frame.
- R5: frame_start_o is 1 for exactly the first bit clock of every high phase and is 0 at all other times.
- R6: Codes programmed for an odd frame length R (high R/2 - 1, low ceil(R/2) - 1) give a frame of exactly R bit clocks, with one more low cycle than high cycles.
- R7: A change to hi_code_i or lo_code_i during a frame does not alter that frame. It takes effect from the next high phase.
- R8: One clock after src_sel_i is sampled at value k+1 (0 <= k < NSRC), src_onehot_o has only bit k set. Value 0, or any value above NSRC, gives all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Generation enable |
| hi_code_i | input | CNT_W | High phase length minus one |
| lo_code_i | input | CNT_W | Low phase length minus one |
| src_sel_i | input | SEL_W | Master-clock source select, k+1 selects source k |
| sync_o | output | 1 | Frame-sync level |
| frame_start_o | output | 1 | One-cycle strobe on the first cycle of each high phase |
| src_onehot_o | output | NSRC | Registered one-hot source select |

## Verification
Some properties are checked on every cycle:
- the counter never passes the captured bound of its phase;
- the captured codes hold steady between frame boundaries;
- the start strobe accompanies every rising edge of sync and never lasts two cycles;
- a low enable forces both outputs low on the next cycle;
- the source vector is at most one-hot.

Other behaviour can only be shown by the bench's scenarios:
- the exact phase lengths for each code pair, including the odd-frame split and the minimum one-cycle phases;
- the timing of a mid-frame period change;
- the exact bit chosen by each select value.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_HIGH = 2'd1,
        FS_LOW  = 2'd2
    } fs_state_e;

endpackage

// File: rtl/fsync_period_regs.sv
module fsync_period_regs #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] hi_code_i,
    input  logic [CNT_W-1:0] lo_code_i,
    output logic [CNT_W-1:0] hi_act_o,
    output logic [CNT_W-1:0] lo_act_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_act_o <= '0;
            lo_act_o <= '0;
        end else if (load_i) begin
            hi_act_o <= hi_code_i;
            lo_act_o <= lo_code_i;
        end
    end

    // R7
    shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> ($stable(hi_act_o) && $stable(lo_act_o)));

endmodule

// File: rtl/fsync_phase_fsm.sv
module fsync_phase_fsm
    import fsync_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] hi_act_i,
    input  logic [CNT_W-1:0] lo_act_i,
    output logic             load_o,
    output logic             sync_o,
    output logic             frame_start_o
);

    fs_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hi_done, lo_done;

    assign hi_done = (cnt_q == hi_act_i);
    assign lo_done = (cnt_q == lo_act_i);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        load_o  = 1'b0;
        if (!enable_i) begin
            state_d = FS_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    state_d = FS_HIGH;
                    cnt_d   = '0;
                    load_o  = 1'b1;
                end
                FS_HIGH: begin
                    if (hi_done) begin
                        state_d = FS_LOW;
                        cnt_d   = '0;
                    end
                end
                FS_LOW: begin
                    if (lo_done) begin
                        state_d = FS_HIGH;
                        cnt_d   = '0;
                        load_o  = 1'b1;
                    end
                end
                default: begin
                    state_d = FS_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        sync_o        = (state_q == FS_HIGH);
        frame_start_o = (state_q == FS_HIGH) && (cnt_q == '0);
    end

    // R3
    hi_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FS_HIGH) |-> (cnt_q <= hi_act_i));

    // R4
    lo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FS_LOW) |-> (cnt_q <= lo_act_i));

endmodule

// File: rtl/fsync_src_decode.sv
module fsync_src_decode #(
    parameter int NSRC  = 6,
    parameter int SEL_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    output logic [NSRC-1:0]  onehot_o
);

    logic [NSRC-1:0] onehot_d;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign onehot_d[k] = (sel_i == SEL_W'(k + 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) onehot_o <= '0;
        else         onehot_o <= onehot_d;
    end

    // R8
    src_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(onehot_o));

    // R8
    src_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == '0) |=> (onehot_o == '0));

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen #(
    parameter int CNT_W = 8,
    parameter int NSRC  = 6,
    parameter int SEL_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] hi_code_i,
    input  logic [CNT_W-1:0] lo_code_i,
    input  logic [SEL_W-1:0] src_sel_i,
    output logic             sync_o,
    output logic             frame_start_o,
    output logic [NSRC-1:0]  src_onehot_o
);

    logic             load;
    logic [CNT_W-1:0] hi_act, lo_act;

    fsync_period_regs #(.CNT_W(CNT_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load),
        .hi_code_i (hi_code_i),
        .lo_code_i (lo_code_i),
        .hi_act_o  (hi_act),
        .lo_act_o  (lo_act)
    );

    fsync_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .enable_i      (enable_i),
        .hi_act_i      (hi_act),
        .lo_act_i      (lo_act),
        .load_o        (load),
        .sync_o        (sync_o),
        .frame_start_o (frame_start_o)
    );

    fsync_src_decode #(.NSRC(NSRC), .SEL_W(SEL_W)) u_src (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_i    (src_sel_i),
        .onehot_o (src_onehot_o)
    );

    // R2
    stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!sync_o && !frame_start_o));

    // R5
    start_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync_o) |-> frame_start_o);

    // R5
    start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |=> !frame_start_o);

endmodule

// File: tb/fsync_gen_test.sv
module fsync_gen_test;

    localparam int CNT_W = 8;
    localparam int NSRC  = 6;
    localparam int SEL_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [CNT_W-1:0] hi = '0;
    logic [CNT_W-1:0] lo = '0;
    logic [SEL_W-1:0] sel = '0;
    logic             sync, fstart;
    logic [NSRC-1:0]  oh;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fsync_gen #(.CNT_W(CNT_W), .NSRC(NSRC), .SEL_W(SEL_W)) uut (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .hi_code_i(hi),
        .lo_code_i(lo), .src_sel_i(sel), .sync_o(sync),
        .frame_start_o(fstart), .src_onehot_o(oh)
    );

    // {hi_code, lo_code}
    localparam logic [15:0] VEC [0:5] = '{
        {8'd0, 8'd0},
        {8'd1, 8'd1},
        {8'd1, 8'd2},
        {8'd3, 8'd3},
        {8'd0, 8'd4},
        {8'd6, 8'd0}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compare sync/start over n cycles against a frame of H high, L low,
    // starting at offset 0 of the frame
    task automatic run_frames(string req, int h, int l, int n);
        int bad = 0;
        logic [1:0] fa = '0, fe = '0;
        for (int i = 0; i < n; i++) begin
            step();
            if ({sync, fstart} !== {((i % (h + l)) < h), ((i % (h + l)) == 0)}
                && bad == 0) begin
                fa = {sync, fstart};
                fe = {((i % (h + l)) < h), ((i % (h + l)) == 0)};
                bad = i + 1;
            end
        end
        check(req, {14'd0, fa}, {14'd0, fe});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NSRC-1:0] exp_oh;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sync/start", {14'd0, sync, fstart}, 16'd0);
        check("R1 onehot", {10'd0, oh}, 16'd0);
        rst_n = 1'b1;
        step();

        // R3 R4 R5 R6: table of period codes
        foreach (VEC[v]) begin
            en = 1'b0;
            step();
            hi = VEC[v][15:8];
            lo = VEC[v][7:0];
            en = 1'b1;
            run_frames($sformatf("R3/R4/R5/R6 vec%0d", v),
                       int'(VEC[v][15:8]) + 1, int'(VEC[v][7:0]) + 1,
                       3 * (int'(VEC[v][15:8]) + int'(VEC[v][7:0]) + 2));
        end

        // R2: stop mid high phase, hold low, restart with high phase
        en = 1'b0; step();
        hi = 8'd3; lo = 8'd3; en = 1'b1;
        step(); step();
        en = 1'b0;
        step();
        check("R2 stop", {14'd0, sync, fstart}, 16'd0);
        step(); step();
        check("R2 hold", {14'd0, sync, fstart}, 16'd0);
        en = 1'b1;
        run_frames("R2 restart", 4, 4, 8);

        // R7: change codes in mid high phase; current frame unchanged
        en = 1'b0; step();
        hi = 8'd1; lo = 8'd1; en = 1'b1;
        step(); // frame A sample 0 (high)
        check("R7 first", {14'd0, sync, fstart}, 16'd3);
        hi = 8'd3; lo = 8'd0;
        step(); check("R7 old hi", {15'd0, sync}, 16'd1);
        step(); check("R7 old lo a", {15'd0, sync}, 16'd0);
        step(); check("R7 old lo b", {15'd0, sync}, 16'd0);
        run_frames("R7 new frame", 4, 1, 10);

        // R8: source select decode
        en = 1'b0;
        for (int s = 0; s < 16; s++) begin
            sel = SEL_W'(s);
            step();
            exp_oh = (s >= 1 && s <= NSRC) ? NSRC'(1) << (s - 1) : '0;
            check($sformatf("R8 sel=%0d", s), {10'd0, oh}, {10'd0, exp_oh});
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule